// File: doc/BRIEF.md
# Dual-Clock Field Memory Channel

This block is one channel of a sequential-access field memory for video lines and fields. It stores 12-bit words in an on-chip RAM whose depth is a parameter. A write port and a read port each run on their own clock. Neither port is given an address. Each side steps its own pointer, under the control of an active-low enable and an active-low clear. The clear sends that pointer back to location zero. No fill level is tracked and no full or empty flags exist. The controlling logic outside the block decides when each pointer is cleared, so one stored field can be read again any number of times.

The read port drives a data word plus an output-enable. The enable is low whenever the previous read-clock edge did not read, which stands in for a bus that is released. Several channels can be instantiated side by side and run with no coupling between them. A single asynchronous active-low reset is synchronised separately into each clock domain.

Top module: `fm_channel`

## Requirements
- R1: On a write-clock edge where `wr_en_n` is 0 and `wr_clr_n` is 1, `wr_data` is stored at the current write pointer and the pointer advances by one.
- R2: On a write-clock edge where `wr_en_n` is 1 and `wr_clr_n` is 1, nothing is stored and the write pointer keeps its value.
- R3: On a write-clock edge where `wr_clr_n` is 0, the write pointer becomes 0 and nothing is stored, whatever `wr_en_n` is.
- R4: On a read-clock edge where `rd_en_n` is 0 and `rd_clr_n` is 1, `rd_data` takes the word at the current read pointer, `rd_oe` becomes 1 at that edge, and the read pointer advances by one.
- R5: On a read-clock edge where `rd_en_n` is 1, `rd_oe` becomes 0, `rd_data` keeps its value, and the read pointer keeps its value.
- R6: On a read-clock edge where `rd_clr_n` is 0, the read pointer becomes 0, `rd_oe` becomes 0, `rd_data` keeps its value, and no word is read, whatever `rd_en_n` is.
- R7: Both pointers step from DEPTH-1 back to 0, with no stall and no flag.
- R8: While `arst_n` is low, and until it has been synchronised into each domain, both pointers are 0, `rd_oe` is 0 and `rd_data` is 0.
- R9: The write and read ports may be active at the same time on unrelated clocks, provided they use different locations. Words read during such activity are the words written earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| arst_n | input | 1 | Asynchronous active-low reset, synchronised into each domain |
| wr_clk | input | 1 | Write-side clock |
| wr_en_n | input | 1 | Active-low write enable |
| wr_clr_n | input | 1 | Active-low write pointer clear |
| wr_data | input | WORD_W | Word to store |
| rd_clk | input | 1 | Read-side clock |
| rd_en_n | input | 1 | Active-low read enable |
| rd_clr_n | input | 1 | Active-low read pointer clear |
| rd_data | output | WORD_W | Registered read word |
| rd_oe | output | 1 | High when rd_data was read at the last read-clock edge |

## Verification
On each port, the clear and the enable can both be active on the same edge, and the clear must win. The bench provokes this on the write side. It first moves the write pointer away from zero, then holds `wr_clr_n` and `wr_en_n` low together with a marker word. After that it rereads both the location the pointer had reached and location zero. The location that was reached must still hold its old word, and location zero must receive only the next enabled write. On the read side the bench asserts both controls together and checks three things: `rd_oe` is low, `rd_data` is unchanged, and the next read returns location zero.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int WORD_W = 12;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/fm_rst_sync.sv
module fm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/fm_addr_ctr.sv
module fm_addr_ctr #(
  parameter int DEPTH  = 16,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_n,
  input  logic          clr_n,
  output logic [AW-1:0] addr,
  output logic          step
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_d;

  // clear beats enable; a clear cycle never counts as an access
  assign step = clr_n & ~en_n;

  always_comb begin
    addr_d = addr_q;
    if (!clr_n)    addr_d = '0;
    else if (step) addr_d = (addr_q == LAST) ? '0 : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/fm_dpram.sv
module fm_dpram #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdata_q;
  logic [W-1:0] rdata_d;

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (re) rdata_d = mem[raddr];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/fm_channel.sv
module fm_channel
  import fm_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              arst_n,
  input  logic              wr_clk,
  input  logic              wr_en_n,
  input  logic              wr_clr_n,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en_n,
  input  logic              rd_clr_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_oe
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          wr_rst_n;
  logic          rd_rst_n;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          wr_step;
  logic          rd_step;
  logic          oe_q;
  logic          oe_d;

  fm_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
    .clk(wr_clk), .arst_n(arst_n), .rst_n(wr_rst_n)
  );

  fm_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
    .clk(rd_clk), .arst_n(arst_n), .rst_n(rd_rst_n)
  );

  fm_addr_ctr #(.DEPTH(DEPTH)) u_wr_ctr (
    .clk(wr_clk), .rst_n(wr_rst_n), .en_n(wr_en_n), .clr_n(wr_clr_n),
    .addr(wr_addr), .step(wr_step)
  );

  fm_addr_ctr #(.DEPTH(DEPTH)) u_rd_ctr (
    .clk(rd_clk), .rst_n(rd_rst_n), .en_n(rd_en_n), .clr_n(rd_clr_n),
    .addr(rd_addr), .step(rd_step)
  );

  fm_dpram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .wclk(wr_clk), .we(wr_step), .waddr(wr_addr), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rd_rst_n), .re(rd_step), .raddr(rd_addr),
    .rdata(rd_data)
  );

  // output enable follows the read strobe through one register, aligned with rd_data
  always_comb begin
    oe_d = rd_step;
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) oe_q <= 1'b0;
    else           oe_q <= oe_d;
  end

  assign rd_oe = oe_q;
endmodule

// File: rtl/fm_channel_chk.sv
module fm_channel_chk #(
  parameter int DEPTH = 16,
  parameter int W     = 12,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          wr_rst_n,
  input logic          rd_rst_n,
  input logic          wr_en_n,
  input logic          wr_clr_n,
  input logic          rd_en_n,
  input logic          rd_clr_n,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_addr,
  input logic          rd_oe,
  input logic [W-1:0]  rd_data
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  // R1 and R7: an enabled write moves the pointer on by one, wrapping at the top
  p_wr_advance_r1: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_clr_n && !wr_en_n) |=>
      (wr_addr == (($past(wr_addr) == LAST) ? '0 : $past(wr_addr) + 1'b1)));

  p_wr_hold_r2: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_clr_n && wr_en_n) |=> $stable(wr_addr));

  p_wr_clear_r3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_clr_n |=> (wr_addr == '0));

  p_rd_oe_on_r4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_clr_n && !rd_en_n) |=> rd_oe);

  p_rd_hold_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_clr_n && rd_en_n) |=> (!rd_oe && $stable(rd_addr) && $stable(rd_data)));

  p_rd_clear_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_clr_n |=> (!rd_oe && rd_addr == '0 && $stable(rd_data)));

  p_rd_wrap_r7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_clr_n && !rd_en_n) |=>
      (rd_addr == (($past(rd_addr) == LAST) ? '0 : $past(rd_addr) + 1'b1)));

  always @(negedge rd_clk) begin
    if (!rd_rst_n) p_rst_state_r8: assert (!rd_oe && rd_addr == '0 && rd_data == '0);
  end
endmodule

bind fm_channel fm_channel_chk #(.DEPTH(DEPTH), .W(fm_pkg::WORD_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .wr_en_n(wr_en_n), .wr_clr_n(wr_clr_n), .rd_en_n(rd_en_n), .rd_clr_n(rd_clr_n),
  .wr_addr(wr_addr), .rd_addr(rd_addr), .rd_oe(rd_oe), .rd_data(rd_data)
);

// File: tb/tb_fm_channel.sv
module tb_fm_channel;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 14;
  localparam int DEPTH      = 16;

  logic        arst_n;
  logic        wr_clk, rd_clk;
  logic        wr_en_n, wr_clr_n, rd_en_n, rd_clr_n;
  logic [11:0] wr_data;
  logic [11:0] rd_data;
  logic        rd_oe;

  int unsigned n_chk;
  int unsigned n_fail;
  logic [11:0] model [DEPTH];
  int          wptr;
  int          rptr;
  logic [11:0] last_q;
  bit          done;

  fm_channel #(.DEPTH(DEPTH)) dut (
    .arst_n(arst_n), .wr_clk(wr_clk), .wr_en_n(wr_en_n), .wr_clr_n(wr_clr_n),
    .wr_data(wr_data), .rd_clk(rd_clk), .rd_en_n(rd_en_n), .rd_clr_n(rd_clr_n),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  initial wr_clk = 1'b0;
  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  initial rd_clk = 1'b0;
  always #(RD_PERIOD/2) rd_clk = ~rd_clk;

  task automatic chk(input string req, input string what,
                     input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_step(input logic en_n, input logic clr_n, input logic [11:0] d);
    @(negedge wr_clk);
    wr_en_n = en_n; wr_clr_n = clr_n; wr_data = d;
    @(negedge wr_clk);
    wr_en_n = 1'b1; wr_clr_n = 1'b1;
    if (!clr_n) wptr = 0;
    else if (!en_n) begin
      model[wptr] = d;
      wptr = (wptr + 1) % DEPTH;
    end
  endtask

  task automatic rd_step(input logic en_n, input logic clr_n, input string req);
    @(negedge rd_clk);
    rd_en_n = en_n; rd_clr_n = clr_n;
    @(negedge rd_clk);
    rd_en_n = 1'b1; rd_clr_n = 1'b1;
    if (clr_n && !en_n) begin
      last_q = model[rptr];
      rptr = (rptr + 1) % DEPTH;
      chk(req, "rd_oe", {11'd0, rd_oe}, 12'd1);
    end else begin
      chk(req, "rd_oe", {11'd0, rd_oe}, 12'd0);
      if (!clr_n) rptr = 0;
    end
    chk(req, "rd_data", rd_data, last_q);
  endtask

  task automatic t_reset();
    chk("R8", "rd_oe after reset", {11'd0, rd_oe}, 12'd0);
    chk("R8", "rd_data after reset", rd_data, 12'd0);
  endtask

  task automatic t_write_read();
    wr_step(1'b1, 1'b0, 12'h000);
    for (int i = 0; i < DEPTH; i++) wr_step(1'b0, 1'b1, 12'((i * 12'h111) ^ 12'hA5C));
    rd_step(1'b1, 1'b0, "R6");
    for (int i = 0; i < DEPTH; i++) rd_step(1'b0, 1'b1, "R4");
  endtask

  task automatic t_write_hold();
    wr_step(1'b1, 1'b0, 12'h000);
    wr_step(1'b0, 1'b1, 12'h3C1);
    wr_step(1'b1, 1'b1, 12'hFFF);   // R2: ignored word
    wr_step(1'b1, 1'b1, 12'hEEE);
    wr_step(1'b0, 1'b1, 12'h3C2);
    rd_step(1'b1, 1'b0, "R6");
    rd_step(1'b0, 1'b1, "R2");
    rd_step(1'b0, 1'b1, "R2");
    rd_step(1'b0, 1'b1, "R2");      // location 2 still holds its earlier word
  endtask

  task automatic t_read_hold();
    rd_step(1'b1, 1'b0, "R6");
    rd_step(1'b0, 1'b1, "R4");
    rd_step(1'b1, 1'b1, "R5");
    rd_step(1'b1, 1'b1, "R5");
    rd_step(1'b0, 1'b1, "R5");      // pointer held: returns location 1
  endtask

  task automatic t_clear_priority();
    wr_step(1'b1, 1'b0, 12'h000);
    for (int i = 0; i < 4; i++) wr_step(1'b0, 1'b1, 12'h700 + 12'(i));
    wr_step(1'b0, 1'b0, 12'hBAD);   // R3: clear with enable, marker must not land
    wr_step(1'b0, 1'b1, 12'h5A5);
    rd_step(1'b0, 1'b0, "R6");      // clear with enable: no read
    for (int i = 0; i < 5; i++) rd_step(1'b0, 1'b1, "R3");
  endtask

  task automatic t_wrap();
    wr_step(1'b1, 1'b0, 12'h000);
    for (int i = 0; i < DEPTH + 2; i++) wr_step(1'b0, 1'b1, 12'h200 + 12'(i * 3));
    rd_step(1'b1, 1'b0, "R6");
    for (int i = 0; i < DEPTH + 2; i++) rd_step(1'b0, 1'b1, "R7");
  endtask

  task automatic t_independent();
    wr_step(1'b1, 1'b0, 12'h000);
    for (int i = 0; i < DEPTH/2; i++) wr_step(1'b0, 1'b1, 12'h900 + 12'(i));
    rd_step(1'b1, 1'b0, "R9");
    fork
      begin
        for (int i = 0; i < DEPTH/2; i++) wr_step(1'b0, 1'b1, 12'h0C0 + 12'(i));
      end
      begin
        for (int i = 0; i < DEPTH/2; i++) rd_step(1'b0, 1'b1, "R9");
      end
    join
    for (int i = 0; i < DEPTH/2; i++) rd_step(1'b0, 1'b1, "R9");
  endtask

  initial begin
    n_chk = 0; n_fail = 0; wptr = 0; rptr = 0; last_q = '0; done = 1'b0;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    arst_n = 1'b0;
    wr_en_n = 1'b1; wr_clr_n = 1'b1; rd_en_n = 1'b1; rd_clr_n = 1'b1;
    wr_data = '0;
    repeat (4) @(negedge rd_clk);
    arst_n = 1'b1;
    repeat (4) @(negedge rd_clk);
    t_reset();
    t_write_read();
    t_write_hold();
    t_read_hold();
    t_clear_priority();
    t_wrap();
    t_independent();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wr_clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule